// File: doc/BRIEF.md
# Background Radix Estimator for a Two-Channel Converter

This block tracks the equivalent radix of one residue stage in each of two parallel converter channels while normal conversion goes on. The channels take the same analog input with opposite polarity, so adding their raw output codes removes the input signal. For each channel the block emits a pseudo-random dither bit that moves that channel's comparator threshold up or down. It multiplies the channel sum by the sign of each channel's own dither bit and accumulates the products over a fixed window of accepted samples. At the end of every window it applies a small, shift-scaled correction to that channel's radix estimate.

An upstream stage presents aligned raw codes with a valid strobe. A code presented with `sample_vld` belongs to the dither bits shown on `dither_p` and `dither_n` in that same cycle. The correction is iterative, a sign-correlation step taken once per window, so an error in the back-end stages does not bias the estimate. A freeze control stops learning. A completion flag tells downstream logic when enough windows have passed for the estimates to be used.

Top module: `radix_cal_top`

## Requirements
- R1: After reset, both radix outputs equal the nominal 2.0 (16384 with 13 fraction bits, 16-bit unsigned), `cal_done` is 0, and `dither_p`/`dither_n` show bit 15 of the seeds 16'hACE1 and 16'h1D2B.
- R2: Each channel's dither comes from a 16-bit shift register s. The output bit is s[15]. On every accepted sample s becomes {s[14:0], s[15]^s[13]^s[12]^s[10]}. A bit of 1 weighs the sample +1 and a bit of 0 weighs it −1.
- R3: The correlated quantity is the signed sum p_code + n_code. Inputs with n_code = −p_code leave both estimates unchanged.
- R4: Each channel accumulates weight × (p_code + n_code) over 2^K accepted samples (K = 4). On the last sample of the window, that sample is included, the estimate becomes estimate − (total >>> (K + step_shift)) with an arithmetic shift, and the accumulator clears. Outside window ends the estimate does not change.
- R5: Every estimate is held within [1.75, 2.25], which is 14336 to 18432.
- R6: `step_shift` sets the extra right shift of the correction. With only a +200 dither-correlated term on p_code and step_shift = 3, each window lowers radix_p by exactly 25.
- R7: While `freeze` is high, accumulators, dither registers, window position and estimates all hold, whatever the codes and the strobe.
- R8: `cal_done` is sticky. It rises in the cycle after the window that brings the completed-window count (saturating at 255) to `done_windows`; a value of 0 acts as 1.
- R9: Cycles with `sample_vld` low change nothing: the dither registers, the accumulators and the estimates all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_vld | input | 1 | Aligned raw codes present this cycle |
| freeze | input | 1 | Hold all learning state |
| p_code | input | 12 | Signed raw code of the positive channel |
| n_code | input | 12 | Signed raw code of the negative channel |
| step_shift | input | 4 | Extra right shift of the correction |
| done_windows | input | 8 | Windows to complete before cal_done |
| dither_p | output | 1 | Threshold dither bit for the positive channel |
| dither_n | output | 1 | Threshold dither bit for the negative channel |
| radix_p | output | 16 | Positive-channel radix estimate, 13 fraction bits |
| radix_n | output | 16 | Negative-channel radix estimate, 13 fraction bits |
| cal_done | output | 1 | Enough windows completed |

## Verification
The hardest states to reach are the two clamp limits and a freeze that falls in the middle of a window. Either needs a systematic correlation between the codes and the dither, which a plain input signal cancels. The stimulus therefore reads the dither bits at the ports and adds a per-channel term of fixed sign that follows each bit. This drives one estimate down and the other up until both clamp, and it gives a clean term whose per-window step can be stated exactly. The freeze is applied a few samples into a window, with garbage codes, so the window that completes afterwards shows whether the accumulator kept its partial sum.

// File: rtl/radix_cal_pkg.sv
package radix_cal_pkg;
  localparam int unsigned PN_W = 16;

  // feedback of x^16 + x^14 + x^13 + x^11 + 1, shifting toward bit 15
  function automatic logic pn_feedback(input logic [PN_W-1:0] s);
    return s[15] ^ s[13] ^ s[12] ^ s[10];
  endfunction
endpackage

// File: rtl/radix_rst_sync.sv
module radix_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/radix_pn_gen.sv
module radix_pn_gen
  import radix_cal_pkg::*;
#(
  parameter logic [PN_W-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic pn_bit
);
  logic [PN_W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (adv) state_d = {state_q[PN_W-2:0], pn_feedback(state_q)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign pn_bit = state_q[PN_W-1];

  // R9 / R7: sequence moves only on accepted samples
  a_r9_pn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q));
endmodule

// File: rtl/radix_window_ctrl.sv
module radix_window_ctrl #(
  parameter int K   = 4,
  parameter int WCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic [WCW-1:0] done_windows,
  output logic           win_end,
  output logic           cal_done
);
  logic [K-1:0]   pos_q, pos_d;
  logic [WCW-1:0] wins_q, wins_d, thr;
  logic [WCW:0]   wins_inc;
  logic           done_q, done_d;

  always_comb begin
    win_end  = adv && (pos_q == '1);
    pos_d    = adv ? pos_q + 1'b1 : pos_q;
    thr      = (done_windows == '0) ? WCW'(1) : done_windows;
    wins_inc = {1'b0, wins_q} + 1'b1;
    wins_d   = (win_end && (wins_q != '1)) ? wins_inc[WCW-1:0] : wins_q;
    done_d   = done_q | (win_end && (wins_inc >= {1'b0, thr}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      wins_q <= '0;
      done_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      wins_q <= wins_d;
      done_q <= done_d;
    end
  end

  assign cal_done = done_q;

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  a_r8_done_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !win_end) |=> !done_q);
endmodule

// File: rtl/radix_corr_accum.sv
module radix_corr_accum #(
  parameter int DW   = 12,
  parameter int K    = 4,
  parameter int RW   = 16,
  parameter int FRAC = 13,
  parameter int SHW  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                win_end,
  input  logic                pn_bit,
  input  logic signed [DW:0]  sum_i,
  input  logic [SHW-1:0]      step_shift,
  output logic [RW-1:0]       est_o
);
  localparam int AW = DW + K + 2;
  localparam int EW = ((AW > RW) ? AW : RW) + 2;
  localparam logic [RW-1:0] NOM = RW'(2 << FRAC);
  localparam logic [RW-1:0] LO  = RW'(7 << (FRAC - 2));
  localparam logic [RW-1:0] HI  = RW'(9 << (FRAC - 2));
  localparam logic signed [EW-1:0] LO_W = EW'(LO);
  localparam logic signed [EW-1:0] HI_W = EW'(HI);

  logic signed [AW-1:0] acc_q, acc_d, term, acc_sum, delta;
  logic signed [EW-1:0] cand;
  logic [RW-1:0]        est_q, est_d, est_clamped;

  always_comb begin
    term    = pn_bit ? AW'(sum_i) : -AW'(sum_i);
    acc_sum = acc_q + term;
    delta   = acc_sum >>> (K + int'(step_shift));
    cand    = $signed({{(EW-RW){1'b0}}, est_q}) - EW'(delta);
    if (cand < LO_W)      est_clamped = LO;
    else if (cand > HI_W) est_clamped = HI;
    else                  est_clamped = cand[RW-1:0];
    est_d = win_end ? est_clamped : est_q;
    acc_d = acc_q;
    if (adv) acc_d = win_end ? '0 : acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      est_q <= NOM;
    end else begin
      acc_q <= acc_d;
      est_q <= est_d;
    end
  end

  assign est_o = est_q;

  a_r4_est_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(est_q));
  a_r4_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (acc_q == '0));
  a_r7_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc_q));
endmodule

// File: rtl/radix_cal_top.sv
module radix_cal_top #(
  parameter int          DW     = 12,
  parameter int          K      = 4,
  parameter int          RW     = 16,
  parameter int          FRAC   = 13,
  parameter int          SHW    = 4,
  parameter int          WCW    = 8,
  parameter logic [15:0] SEED_P = 16'hACE1,
  parameter logic [15:0] SEED_N = 16'h1D2B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_vld,
  input  logic                 freeze,
  input  logic signed [DW-1:0] p_code,
  input  logic signed [DW-1:0] n_code,
  input  logic [SHW-1:0]       step_shift,
  input  logic [WCW-1:0]       done_windows,
  output logic                 dither_p,
  output logic                 dither_n,
  output logic [RW-1:0]        radix_p,
  output logic [RW-1:0]        radix_n,
  output logic                 cal_done
);
  localparam int NCH = 2;
  localparam logic [RW-1:0] LO = RW'(7 << (FRAC - 2));
  localparam logic [RW-1:0] HI = RW'(9 << (FRAC - 2));

  logic              rst_int;
  logic              adv, win_end;
  logic signed [DW:0] code_sum;
  logic [NCH-1:0]    pn;
  logic [RW-1:0]     est [NCH];

  radix_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int));

  assign adv      = sample_vld & ~freeze;
  assign code_sum = {p_code[DW-1], p_code} + {n_code[DW-1], n_code};

  radix_window_ctrl #(.K(K), .WCW(WCW)) u_win (
    .clk(clk), .rst_n(rst_int), .adv(adv), .done_windows(done_windows),
    .win_end(win_end), .cal_done(cal_done)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [15:0] SEED = (ch == 0) ? SEED_P : SEED_N;

    radix_pn_gen #(.SEED(SEED)) u_pn (
      .clk(clk), .rst_n(rst_int), .adv(adv), .pn_bit(pn[ch])
    );

    radix_corr_accum #(.DW(DW), .K(K), .RW(RW), .FRAC(FRAC), .SHW(SHW)) u_acc (
      .clk(clk), .rst_n(rst_int), .adv(adv), .win_end(win_end),
      .pn_bit(pn[ch]), .sum_i(code_sum), .step_shift(step_shift),
      .est_o(est[ch])
    );
  end

  assign dither_p = pn[0];
  assign dither_n = pn[1];
  assign radix_p  = est[0];
  assign radix_n  = est[1];

  a_r5_range_p: assert property (@(posedge clk) disable iff (!rst_int)
    (radix_p >= LO) && (radix_p <= HI));
  a_r5_range_n: assert property (@(posedge clk) disable iff (!rst_int)
    (radix_n >= LO) && (radix_n <= HI));
  a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_int)
    freeze |=> ($stable(radix_p) && $stable(radix_n) && $stable(dither_p) && $stable(dither_n)));
endmodule

// File: tb/radix_cal_top_tb_top.sv
module radix_cal_top_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic sample_vld, freeze;
  logic signed [11:0] p_code, n_code;
  logic [3:0]  step_shift;
  logic [7:0]  done_windows;
  logic dither_p, dither_n, cal_done;
  logic [15:0] radix_p, radix_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  // behavioural reference state
  logic [15:0] m_pn [2];
  int m_est [2];
  int m_q0 [$];
  int m_q1 [$];
  int m_wins;
  bit m_done;

  always #2 clk = ~clk;

  radix_cal_top dut_i (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .freeze(freeze),
    .p_code(p_code), .n_code(n_code), .step_shift(step_shift),
    .done_windows(done_windows), .dither_p(dither_p), .dither_n(dither_n),
    .radix_p(radix_p), .radix_n(radix_n), .cal_done(cal_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v < 14336) return 14336;
    if (v > 18432) return 18432;
    return v;
  endfunction

  function automatic logic [15:0] pn_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic model_reset();
    m_pn[0] = 16'hACE1;
    m_pn[1] = 16'h1D2B;
    m_est[0] = 16384;
    m_est[1] = 16384;
    m_q0.delete();
    m_q1.delete();
    m_wins = 0;
    m_done = 0;
  endtask

  task automatic model_step(input bit vld, input bit frz, input int p, input int n);
    int s, t0, t1, thr;
    if (vld && !frz) begin
      s = p + n;
      m_q0.push_back(m_pn[0][15] ? s : -s);
      m_q1.push_back(m_pn[1][15] ? s : -s);
      m_pn[0] = pn_next(m_pn[0]);
      m_pn[1] = pn_next(m_pn[1]);
      if (m_q0.size() == 16) begin
        t0 = 0;
        t1 = 0;
        foreach (m_q0[i]) t0 += m_q0[i];
        foreach (m_q1[i]) t1 += m_q1[i];
        m_est[0] = clampv(m_est[0] - (t0 >>> (4 + int'(step_shift))));
        m_est[1] = clampv(m_est[1] - (t1 >>> (4 + int'(step_shift))));
        m_q0.delete();
        m_q1.delete();
        if (m_wins < 255) m_wins++;
        thr = (done_windows == 0) ? 1 : int'(done_windows);
        if (m_wins >= thr) m_done = 1;
      end
    end
  endtask

  task automatic compare_all();
    check(dither_p == m_pn[0][15], "R2 dither_p", int'(dither_p), int'(m_pn[0][15]));
    check(dither_n == m_pn[1][15], "R2 dither_n", int'(dither_n), int'(m_pn[1][15]));
    check(int'(radix_p) == m_est[0], "R4 radix_p", int'(radix_p), m_est[0]);
    check(int'(radix_n) == m_est[1], "R4 radix_n", int'(radix_n), m_est[1]);
    check(cal_done == m_done, "R8 cal_done", int'(cal_done), int'(m_done));
  endtask

  // one clock: inputs applied now, consumed at next posedge, compared at the negedge after
  task automatic tick(input bit vld, input bit frz, input int p, input int n);
    sample_vld = vld;
    freeze = frz;
    p_code = 12'(p);
    n_code = 12'(n);
    @(posedge clk);
    @(negedge clk);
    if (rst_n) model_step(vld, frz, p, n);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) tick(0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) tick(0, 0, 0, 0);
  endtask

  // sample whose P part carries a term a following dither_p and N part b following dither_n
  task automatic dsample(input int a, input int b);
    int x, sp, sn;
    x = int'($urandom_range(0, 3000)) - 1500;
    sp = dither_p ? a : -a;
    sn = dither_n ? b : -b;
    if (x + sp > 2047 || x + sp < -2048) x = 0;
    tick(1, 0, x + sp, -x + sn);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hold_p, hold_n;
    bit hold_dp, hold_dn;
    sample_vld = 0; freeze = 0; p_code = 0; n_code = 0;
    step_shift = 4'd0; done_windows = 8'd3;
    do_reset();
    // R1 reset state
    check(radix_p == 16'd16384, "R1 radix_p reset", int'(radix_p), 16384);
    check(radix_n == 16'd16384, "R1 radix_n reset", int'(radix_n), 16384);
    check(cal_done == 1'b0, "R1 cal_done reset", int'(cal_done), 0);
    check(dither_p == 1'b1, "R1 dither_p seed", int'(dither_p), 1);
    check(dither_n == 1'b0, "R1 dither_n seed", int'(dither_n), 0);

    // R3: opposite-polarity signal cancels; R8 after two windows not done
    repeat (32) dsample(0, 0);
    check(radix_p == 16'd16384, "R3 radix_p unchanged", int'(radix_p), 16384);
    check(radix_n == 16'd16384, "R3 radix_n unchanged", int'(radix_n), 16384);
    check(cal_done == 1'b0, "R8 not done after 2 of 3", int'(cal_done), 0);
    repeat (16) dsample(0, 0);
    check(cal_done == 1'b1, "R8 done after 3 windows", int'(cal_done), 1);

    // R9: idle cycles with garbage codes change nothing
    hold_dp = dither_p; hold_dn = dither_n;
    repeat (10) tick(0, 0, 1999, 1999);
    check(dither_p == hold_dp, "R9 dither_p idle", int'(dither_p), int'(hold_dp));
    check(dither_n == hold_dn, "R9 dither_n idle", int'(dither_n), int'(hold_dn));
    check(radix_p == 16'd16384, "R9 radix_p idle", int'(radix_p), 16384);
    repeat (16) begin
      dsample(0, 0);
      tick(0, 0, -1500, -1500);
    end

    // R5: correlated terms drive P down to the lower clamp and N up to the upper clamp
    repeat (16 * 25) dsample(200, -150);
    check(radix_p == 16'd14336, "R5 radix_p low clamp", int'(radix_p), 14336);
    check(radix_n == 16'd18432, "R5 radix_n high clamp", int'(radix_n), 18432);
    repeat (32) dsample(200, -150);
    check(radix_p == 16'd14336, "R5 radix_p stays clamped", int'(radix_p), 14336);

    // R6: step shift 3 with a clean +200 term gives exactly 25 per window
    step_shift = 4'd3;
    do_reset();
    repeat (16 * 4) dsample(200, 0);
    check(radix_p == 16'd16284, "R6 four windows shift 3", int'(radix_p), 16284);

    // R7: freeze in mid-window with garbage codes, then finish the window
    repeat (5) dsample(200, 0);
    hold_p = int'(radix_p); hold_n = int'(radix_n);
    hold_dp = dither_p; hold_dn = dither_n;
    repeat (20) tick(1, 1, 2000, 2000);
    check(int'(radix_p) == hold_p, "R7 radix_p frozen", int'(radix_p), hold_p);
    check(int'(radix_n) == hold_n, "R7 radix_n frozen", int'(radix_n), hold_n);
    check(dither_p == hold_dp, "R7 dither_p frozen", int'(dither_p), int'(hold_dp));
    check(dither_n == hold_dn, "R7 dither_n frozen", int'(dither_n), int'(hold_dn));
    repeat (11) dsample(200, 0);
    check(radix_p == 16'd16259, "R7 partial sum kept across freeze", int'(radix_p), 16259);

    // R4: step shift 0 with clean term moves exactly 200 per window
    step_shift = 4'd0;
    repeat (16) dsample(200, 0);
    check(radix_p == 16'd16059, "R4 one window shift 0", int'(radix_p), 16059);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule